// File: doc/BRIEF.md
# Processor Interrupt Entry Arbiter

This block sits in front of a processor core and decides when an interrupt is taken and which 8-bit vector number goes with it. It watches two request sources. The first is a non-maskable pin that may change at any time relative to the clock and counts only on a qualified low-to-high edge. The second is a level-sensitive maskable request that is gated by an interrupt-enable flag. The block owns that flag. The core sets or clears it with strobes, and every interrupt entry clears it.

A non-maskable entry always uses vector 2 and needs no bus traffic. A maskable entry first runs two interrupt-acknowledge bus cycles toward an external vector controller. Each cycle is a request/ready handshake: `ack_req_o` rises and stays high, with `ack_second_o` steady, until the controller answers with `ack_rdy_i`. The controller can stall either cycle for any number of clocks. The vector is sampled from `ack_data_i` on the ready of the second cycle. Every entry ends in a one-clock `take_o` pulse with `take_vec_o` valid in that clock.

The block keeps a last-in first-out record of the handlers in progress. A return strobe therefore releases the non-maskable block only when the handler being left is the non-maskable one. While that handler runs, one further qualified non-maskable edge is held pending, and any others are dropped.

Top module: `irq_entry_arb`

## Requirements
- R1: After reset, `take_o`, `ack_req_o` and `ie_o` are 0.
- R2: A non-maskable event is recognised when the synchronised pin has been low for at least 8 clocks, rises, and then stays high for 8 clocks. It produces exactly one `take_o` pulse with `take_vec_o` = 2 and no acknowledge cycles.
- R3: A pin pattern with fewer than 8 low clocks before the rise, or fewer than 8 high clocks after it, produces no `take_o`.
- R4: With `ie_o` = 1 and `mreq_i` = 1, the block runs two acknowledge cycles. The first has `ack_second_o` = 0 and the second has `ack_second_o` = 1. Each holds `ack_req_o` = 1 with `ack_second_o` unchanged until `ack_rdy_i` is 1. The `take_o` pulse carries the `ack_data_i` value present at the second ready.
- R5: While `ie_o` = 0, `mreq_i` starts no acknowledge cycle. The request is not latched: it is served after `ie_set_i` only if `mreq_i` is still 1.
- R6: `ie_o` becomes 1 one clock after an `ie_set_i` strobe and 0 one clock after an `ie_clr_i` strobe, with clear winning. Every entry forces `ie_o` to 0, so `ie_o` = 0 whenever `take_o` = 1.
- R7: While a non-maskable handler is active, one further non-maskable event is held and taken with vector 2 after the return from that handler. Additional events in that time are dropped.
- R8: When a pending non-maskable event and an enabled maskable request are eligible in the same clock, the non-maskable entry is taken. Because that entry clears `ie_o`, no acknowledge cycle follows.
- R9: Entries nest last-in first-out. An enabled maskable request is taken inside a non-maskable handler. A return from that maskable handler does not release a pending non-maskable event; the return from the non-maskable handler does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nmi_pin_i | input | 1 | Asynchronous non-maskable request pin |
| mreq_i | input | 1 | Level-sensitive maskable request |
| ie_set_i | input | 1 | Strobe: set the interrupt-enable flag |
| ie_clr_i | input | 1 | Strobe: clear the interrupt-enable flag |
| iret_i | input | 1 | Strobe: the core returns from the innermost handler |
| ack_req_o | output | 1 | Acknowledge bus cycle requested |
| ack_second_o | output | 1 | 0 during the first acknowledge cycle, 1 during the second |
| ack_rdy_i | input | 1 | Vector controller completes the current acknowledge cycle |
| ack_data_i | input | VW | Vector from the controller, sampled at the second ready |
| ie_o | output | 1 | Interrupt-enable flag |
| take_o | output | 1 | One-clock interrupt entry pulse |
| take_vec_o | output | VW | Vector number of the entry, valid with `take_o` |

## Verification
The non-maskable qualifier is driven with a table of low/high lengths: exactly 8/8, longer phases on both sides, and each side one clock short. The table separates an accepted edge from an edge rejected for a short low phase or a short high phase. The maskable path is driven once with a stalled controller, which shows the request holding steady through back-pressure in each phase. It is also driven with requests arriving while the flag is clear, which separates a held request from one that was withdrawn. Sequences of several non-maskable edges inside a handler, a coincident return plus enable, and a maskable handler nested in a non-maskable one separate the single pending slot, the priority order, and the return that actually releases the block.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ACK_A, ST_ACK_B} ent_state_t;
  localparam int NMI_VEC_NUM = 2;
endpackage

// File: rtl/nmi_qualifier.sv
module nmi_qualifier #(
  parameter int QUAL = 8,
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic event_o
);
  localparam int CW = $clog2(QUAL + 1);

  logic [SYNC-1:0] sync_q;
  logic            s, s_prev, armed;
  logic [CW-1:0]   lo_cnt, hi_cnt;
  logic            rise;

  assign s    = sync_q[SYNC-1];
  assign rise = s & ~s_prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= '0;
      s_prev <= 1'b0;
      lo_cnt <= '0;
      hi_cnt <= '0;
      armed  <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC-2:0], pin_i};
      s_prev <= s;
      // saturating run lengths of the synchronised level
      if (!s) lo_cnt <= (lo_cnt == CW'(QUAL)) ? lo_cnt : lo_cnt + 1'b1;
      else    lo_cnt <= '0;
      if (!s) hi_cnt <= '0;
      else if (hi_cnt != CW'(QUAL)) hi_cnt <= hi_cnt + 1'b1;
      if (!s || event_o) armed <= 1'b0;
      else if (rise && lo_cnt == CW'(QUAL)) armed <= 1'b1;
    end
  end

  assign event_o = armed & s & (hi_cnt == CW'(QUAL - 1));

  // R2: an accepted edge has been high in the clock before it as well
  p_event_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
    event_o |-> $past(s));
  // R3: a drop of the level cancels any edge under qualification
  p_drop_disarms_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(s) |=> !armed);
endmodule

// File: rtl/handler_stack.sv
module handler_stack #(
  parameter int DEPTH = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic push_i,
  input  logic kind_i,
  input  logic pop_i,
  output logic top_kind_o,
  output logic empty_o
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [DEPTH-1:0] kinds_q;
  logic [CW-1:0]    cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      kinds_q <= '0;
      cnt_q   <= '0;
    end else if (push_i) begin
      kinds_q <= {kinds_q[DEPTH-2:0], kind_i};
      cnt_q   <= cnt_q + 1'b1;
    end else if (pop_i && cnt_q != '0) begin
      kinds_q <= {1'b0, kinds_q[DEPTH-1:1]};
      cnt_q   <= cnt_q - 1'b1;
    end
  end

  assign top_kind_o = kinds_q[0];
  assign empty_o    = (cnt_q == '0);

  // R9: nesting never exceeds the record depth
  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |-> cnt_q < CW'(DEPTH));
endmodule

// File: rtl/irq_entry_arb.sv
module irq_entry_arb
  import irq_arb_pkg::*;
#(
  parameter int QUAL  = 8,
  parameter int SYNC  = 2,
  parameter int NEST  = 4,
  parameter int VW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          nmi_pin_i,
  input  logic          mreq_i,
  input  logic          ie_set_i,
  input  logic          ie_clr_i,
  input  logic          iret_i,
  output logic          ack_req_o,
  output logic          ack_second_o,
  input  logic          ack_rdy_i,
  input  logic [VW-1:0] ack_data_i,
  output logic          ie_o,
  output logic          take_o,
  output logic [VW-1:0] take_vec_o
);
  localparam logic [VW-1:0] NMI_VEC = VW'(NMI_VEC_NUM);

  ent_state_t    state_q;
  logic          nmi_evt, nmi_pend_q, nmi_busy_q;
  logic          take_nmi, start_ack, done_ack;
  logic          top_kind, stk_empty;
  logic          ie_q, take_q;
  logic [VW-1:0] vec_q;

  nmi_qualifier #(.QUAL(QUAL), .SYNC(SYNC)) u_qual (
    .clk(clk), .rst_n(rst_n), .pin_i(nmi_pin_i), .event_o(nmi_evt)
  );

  handler_stack #(.DEPTH(NEST)) u_stk (
    .clk(clk), .rst_n(rst_n),
    .push_i(take_nmi | done_ack), .kind_i(take_nmi), .pop_i(iret_i),
    .top_kind_o(top_kind), .empty_o(stk_empty)
  );

  // non-maskable first, then an enabled maskable level
  assign take_nmi  = (state_q == ST_IDLE) & nmi_pend_q & ~nmi_busy_q;
  assign start_ack = (state_q == ST_IDLE) & ~take_nmi & mreq_i & ie_q;
  assign done_ack  = (state_q == ST_ACK_B) & ack_rdy_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      nmi_pend_q <= 1'b0;
      nmi_busy_q <= 1'b0;
      ie_q       <= 1'b0;
      take_q     <= 1'b0;
      vec_q      <= '0;
    end else begin
      case (state_q)
        ST_IDLE:  if (start_ack) state_q <= ST_ACK_A;
        ST_ACK_A: if (ack_rdy_i) state_q <= ST_ACK_B;
        ST_ACK_B: if (ack_rdy_i) state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
      // a single pending slot; events while it is full are lost
      nmi_pend_q <= (nmi_pend_q & ~take_nmi) | nmi_evt;
      if (take_nmi) nmi_busy_q <= 1'b1;
      else if (iret_i && !stk_empty && top_kind) nmi_busy_q <= 1'b0;
      if (take_nmi || start_ack || done_ack || ie_clr_i) ie_q <= 1'b0;
      else if (ie_set_i) ie_q <= 1'b1;
      take_q <= take_nmi | done_ack;
      if (take_nmi)      vec_q <= NMI_VEC;
      else if (done_ack) vec_q <= ack_data_i;
    end
  end

  assign ack_req_o    = (state_q != ST_IDLE);
  assign ack_second_o = (state_q == ST_ACK_B);
  assign ie_o         = ie_q;
  assign take_o       = take_q;
  assign take_vec_o   = vec_q;

  // R4: a stalled acknowledge cycle keeps its request and phase
  p_ack_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ack_req_o && !ack_rdy_i |=> ack_req_o && $stable(ack_second_o));
  // R4: the second phase follows a completed first phase
  p_ack_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_second_o) |-> $past(ack_req_o && !ack_second_o && ack_rdy_i));
  // R5: an acknowledge sequence only starts from an enabled request
  p_masked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_req_o) |-> $past(ie_o && mreq_i));
  // R6: the flag is clear whenever an entry is signalled
  p_ie_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> !ie_o);
  // R7: a non-maskable handler begins only with a vector-2 entry
  p_nmi_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nmi_busy_q) |-> take_o && take_vec_o == NMI_VEC);
endmodule

// File: tb/sim_irq_entry_arb.sv
`timescale 1ns/1ps
module sim_irq_entry_arb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic nmi_pin = 1'b0, mreq = 1'b0, ie_set = 1'b0, ie_clr = 1'b0, iret = 1'b0;
  logic ack_req, ack_second, ack_rdy, ie, take;
  logic [7:0] ack_data, take_vec;
  logic auto_ack = 1'b0, m_rdy = 1'b0, a_rdy = 1'b0;
  logic [7:0] auto_vec = 8'h00, m_data = 8'h00, a_data = 8'h00;
  int n_chk = 0, n_err = 0, ntake = 0, nack = 0, last_vec = 0;
  bit done = 0;

  always #2 clk = ~clk;

  assign ack_rdy  = auto_ack ? a_rdy : m_rdy;
  assign ack_data = auto_ack ? a_data : m_data;

  irq_entry_arb u0 (
    .clk(clk), .rst_n(rst_n), .nmi_pin_i(nmi_pin), .mreq_i(mreq),
    .ie_set_i(ie_set), .ie_clr_i(ie_clr), .iret_i(iret),
    .ack_req_o(ack_req), .ack_second_o(ack_second), .ack_rdy_i(ack_rdy),
    .ack_data_i(ack_data), .ie_o(ie), .take_o(take), .take_vec_o(take_vec)
  );

  // low clocks, high clocks, expected entries
  localparam int PAT [6][3] = '{'{8,8,1}, '{7,8,0}, '{8,7,0},
                                '{20,12,1}, '{3,30,0}, '{12,8,1}};

  always @(posedge clk) begin
    #1;
    if (take) begin ntake++; last_vec = int'(take_vec); end
    if (ack_req) nack++;
  end

  always @(negedge clk) begin
    a_rdy  = ack_req;
    a_data = ack_second ? auto_vec : 8'h00;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic strobe_ret();
    iret = 1'b1; tick(1); iret = 1'b0;
  endtask

  task automatic strobe_ie_set();
    ie_set = 1'b1; tick(1); ie_set = 1'b0;
  endtask

  task automatic strobe_ie_clr();
    ie_clr = 1'b1; tick(1); ie_clr = 1'b0;
  endtask

  task automatic nmi_pulse();
    nmi_pin = 1'b0; tick(10);
    nmi_pin = 1'b1; tick(10);
    nmi_pin = 1'b0; tick(4);
  endtask

  initial begin
    int t0, a0;
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R1 reset state
    chk("R1 take", int'(take), 0);
    chk("R1 ack_req", int'(ack_req), 0);
    chk("R1 ie", int'(ie), 0);
    tick(10);

    // R2 / R3 qualification table
    for (int i = 0; i < 6; i++) begin
      t0 = ntake; a0 = nack;
      nmi_pin = 1'b1; tick(3);
      nmi_pin = 1'b0; tick(PAT[i][0]);
      nmi_pin = 1'b1; tick(PAT[i][1]);
      nmi_pin = 1'b0; tick(8);
      chk(PAT[i][2] != 0 ? "R2 accepted edge" : "R3 rejected edge", ntake - t0, PAT[i][2]);
      chk("R2 no ack cycles", nack - a0, 0);
      if (PAT[i][2] != 0) begin
        chk("R2 vector", last_vec, 2);
        strobe_ret();
      end
      tick(10);
    end

    // R4 stalled two-phase acknowledge, R6 flag cleared on entry
    strobe_ie_set();
    chk("R6 ie set", int'(ie), 1);
    strobe_ie_clr();
    chk("R6 ie clr", int'(ie), 0);
    ie_set = 1'b1; ie_clr = 1'b1; tick(1); ie_set = 1'b0; ie_clr = 1'b0;
    chk("R6 clear wins", int'(ie), 0);
    strobe_ie_set();
    t0 = ntake;
    mreq = 1'b1;
    for (int k = 0; k < 10 && !ack_req; k++) tick(1);
    chk("R4 first phase", int'(ack_req) * 2 + int'(ack_second), 2);
    tick(3);
    chk("R4 hold first", int'(ack_req) * 2 + int'(ack_second), 2);
    m_rdy = 1'b1; tick(1); m_rdy = 1'b0;
    chk("R4 second phase", int'(ack_req) * 2 + int'(ack_second), 3);
    tick(2);
    chk("R4 hold second", int'(ack_req) * 2 + int'(ack_second), 3);
    chk("R4 no early take", ntake - t0, 0);
    m_rdy = 1'b1; m_data = 8'h47; tick(1); m_rdy = 1'b0; m_data = 8'h00;
    tick(1);
    chk("R4 take count", ntake - t0, 1);
    chk("R4 vector", last_vec, 8'h47);
    chk("R6 ie after entry", int'(ie), 0);
    mreq = 1'b0;
    strobe_ret();
    tick(5);

    // R5 masked request, held and withdrawn
    auto_ack = 1'b1; auto_vec = 8'h5A;
    t0 = ntake; a0 = nack;
    mreq = 1'b1; tick(20);
    chk("R5 masked no ack", nack - a0, 0);
    chk("R5 masked no take", ntake - t0, 0);
    strobe_ie_set(); tick(8);
    chk("R5 held served", ntake - t0, 1);
    chk("R5 held vector", last_vec, 8'h5A);
    mreq = 1'b0;
    strobe_ret(); tick(3);
    t0 = ntake; a0 = nack;
    mreq = 1'b1; tick(5); mreq = 1'b0;
    strobe_ie_set(); tick(15);
    chk("R5 withdrawn no take", ntake - t0, 0);
    chk("R5 withdrawn no ack", nack - a0, 0);
    strobe_ie_clr();

    // R7 one pending event, extras dropped
    t0 = ntake;
    nmi_pulse();
    chk("R7 first entry", ntake - t0, 1);
    nmi_pulse();
    nmi_pulse();
    chk("R7 blocked in handler", ntake - t0, 1);
    strobe_ret(); tick(4);
    chk("R7 pending taken", ntake - t0, 2);
    chk("R7 pending vector", last_vec, 2);
    strobe_ret(); tick(40);
    chk("R7 extra dropped", ntake - t0, 2);

    // R8 coincident eligibility
    t0 = ntake;
    nmi_pulse();
    mreq = 1'b1;
    nmi_pulse();
    a0 = nack;
    iret = 1'b1; ie_set = 1'b1; tick(1); iret = 1'b0; ie_set = 1'b0;
    tick(3);
    chk("R8 nmi first", ntake - t0, 2);
    chk("R8 vector", last_vec, 2);
    chk("R8 ie cleared", int'(ie), 0);
    tick(10);
    chk("R8 no ack after", nack - a0, 0);
    mreq = 1'b0;
    strobe_ret(); tick(5);

    // R9 nesting and the releasing return
    auto_vec = 8'h33;
    t0 = ntake;
    nmi_pulse();
    strobe_ie_set();
    mreq = 1'b1; tick(8); mreq = 1'b0;
    chk("R9 nested taken", ntake - t0, 2);
    chk("R9 nested vector", last_vec, 8'h33);
    nmi_pulse();
    strobe_ret(); tick(20);
    chk("R9 inner return keeps block", ntake - t0, 2);
    strobe_ret(); tick(3);
    chk("R9 outer return releases", ntake - t0, 3);
    chk("R9 released vector", last_vec, 2);
    strobe_ret(); tick(5);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule